// File: doc/BRIEF.md
# Timer Channel Polarity, Gating and Capture Stage

This block is one capture/compare channel of a general-purpose timer. Its behaviour is set by a 16-bit control word that holds three live bits: an enable, a polarity bit and a second polarity bit that is only meaningful for capture. A mode input selects how the channel reads those bits.

In output mode the stage takes a reference waveform from the compare logic. It inverts the waveform when the polarity bit asks for it, and then either drives the result onto the pin with the pin-enable raised, or holds both the pin and its enable low. In input mode the stage passes the pin through a two-flop synchronizer and then applies the selected inversion. It looks for a rising edge, a falling edge or any change, whichever the two polarity bits select. On that edge it copies the free-running count into a 16-bit capture register and raises a sticky flag. The copy happens only if the enable bit permits it.

Top module: `tmr_chan_stage`

## Requirements
- R1: After reset the control word reads 0x0000, the captured value is 0, the capture flag is 0 and the pin-enable output is 0.
- R2: A write to the control word stores only bit 0 (enable), bit 1 (polarity) and bit 3 (capture polarity). All other bits always read back as 0. A write takes effect from the next clock edge.
- R3: In output mode (mode_in=0) with the enable at 0, pin_out and pin_oe are both 0.
- R4: In output mode with the enable at 1, pin_oe is 1 and pin_out equals ref_in when the polarity bit is 0, and the inverse of ref_in when it is 1.
- R5: In output mode, bit 3 has no effect on pin_out or pin_oe.
- R6: In input mode (mode_in=1), pin_out and pin_oe are 0.
- R7: In input mode the two-bit code {bit3, bit1} = 00 captures on a rising pin edge. The count present on the clock edge is stored three rising clock edges after the pin change, and it is not yet visible after the second.
- R8: Code 01 captures on a falling pin edge, with the same latency.
- R9: Code 11 captures on both rising and falling pin edges, with the same latency.
- R10: Code 10 never captures, on any pin edge.
- R11: With the enable at 0, or in output mode, no pin edge changes the captured value or the flag.
- R12: The capture flag is set by every capture and stays set. A flag write with data 0 clears it and a flag write with data 1 has no effect. A capture in the same cycle as a clearing write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_in | input | 1 | 1 = input (capture) mode, 0 = output mode |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back |
| ref_in | input | 1 | Reference waveform from compare logic |
| pin_in | input | 1 | Asynchronous pin level for capture |
| count_in | input | 16 | Free-running counter value |
| flag_we | input | 1 | Capture flag write strobe |
| flag_wdata | input | 1 | Capture flag write data (0 clears) |
| pin_out | output | 1 | Conditioned output pin value |
| pin_oe | output | 1 | Output pin enable |
| cap_value | output | 16 | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The output path is combinational from the stored control word, so its results are due in the same cycle as ref_in and one edge after a control write. The bench samples them at the falling edge after the write completes. A capture needs three rising edges after a pin change: two synchronizer stages, then the capture register. The bench drives the pin on a falling edge and checks that the captured value is unchanged after two rising edges and updated after the third. Each capture trial first parks the pin with the channel disabled for several cycles, so that no stale edge leaks into the next trial.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic cpol;
        logic pol;
        logic en;
    } chan_cfg_t;

endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
    import tmr_chan_pkg::*;
#(
    parameter int unsigned REG_W    = 16,
    parameter int unsigned EN_BIT   = 0,
    parameter int unsigned POL_BIT  = 1,
    parameter int unsigned CPOL_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output chan_cfg_t        cfg
);

    chan_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.en   = wdata[EN_BIT];
            cfg_d.pol  = wdata[POL_BIT];
            cfg_d.cpol = wdata[CPOL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata           = '0;
        rdata[EN_BIT]   = cfg_q.en;
        rdata[POL_BIT]  = cfg_q.pol;
        rdata[CPOL_BIT] = cfg_q.cpol;
    end

    assign cfg = cfg_q;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rdata) <= 3);

endmodule

// File: rtl/chan_in_cond.sv
module chan_in_cond
    import tmr_chan_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  edge_sel_e edge_sel,
    output logic      edge_hit
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } cond_st_t;

    cond_st_t st_d, st_q;
    logic     invert, cond_now, cond_prev;

    always_comb begin
        st_d = st_q;
        for (int i = LAST; i > 0; i--) st_d.sync[i] = st_q.sync[i-1];
        st_d.sync[0] = pin_in;
        st_d.prev    = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        invert    = (edge_sel == EDGE_FALL);
        cond_now  = st_q.sync[LAST] ^ invert;
        cond_prev = st_q.prev ^ invert;
        unique case (edge_sel)
            EDGE_RISE, EDGE_FALL: edge_hit = cond_now & ~cond_prev;
            EDGE_BOTH:            edge_hit = cond_now ^ cond_prev;
            default:              edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/chan_capture.sv
module chan_capture #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] count_in,
    input  logic             flag_we,
    input  logic             flag_wdata,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             flag;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = edge_hit & cap_en;
        if (flag_we && !flag_wdata) st_d.flag = 1'b0;
        if (take) begin
            st_d.value = count_in;
            st_d.flag  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_value = st_q.value;
    assign cap_flag  = st_q.flag;

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !(flag_we && !flag_wdata)) |=> cap_flag);

    // R11
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(cap_value) && !$rose(cap_flag)));

endmodule

// File: rtl/chan_out_gate.sv
module chan_out_gate
    import tmr_chan_pkg::*;
(
    input  logic      mode_in,
    input  chan_cfg_t cfg,
    input  logic      ref_in,
    output logic      pin_out,
    output logic      pin_oe
);

    always_comb begin
        pin_oe  = !mode_in && cfg.en;
        pin_out = pin_oe ? (ref_in ^ cfg.pol) : 1'b0;
    end

endmodule

// File: rtl/tmr_chan_stage.sv
module tmr_chan_stage
    import tmr_chan_pkg::*;
#(
    parameter int unsigned REG_W       = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             ref_in,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             flag_we,
    input  logic             flag_wdata,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag
);

    chan_cfg_t cfg;
    edge_sel_e edge_sel;
    logic      edge_hit;
    logic      cap_en;

    assign edge_sel = edge_sel_e'({cfg.cpol, cfg.pol});
    assign cap_en   = mode_in & cfg.en;

    chan_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    chan_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (edge_sel),
        .edge_hit (edge_hit)
    );

    chan_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit   (edge_hit),
        .cap_en     (cap_en),
        .count_in   (count_in),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .cap_value  (cap_value),
        .cap_flag   (cap_flag)
    );

    chan_out_gate u_out (
        .mode_in (mode_in),
        .cfg     (cfg),
        .ref_in  (ref_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R3
    out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_in && !cfg_rdata[0]) |-> (!pin_out && !pin_oe));

    // R4
    out_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_in && cfg_rdata[0]) |-> (pin_oe && (pin_out == (ref_in ^ cfg_rdata[1]))));

    // R6
    in_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_in |-> (!pin_oe && !pin_out));

    // R10
    rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3] && !cfg_rdata[1]) |=> $stable(cap_value));

endmodule

// File: tb/test_tmr_chan_stage.sv
module test_tmr_chan_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        ref_in = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] count_in = '0;
    logic        flag_we = 1'b0;
    logic        flag_wdata = 1'b0;
    logic        pin_out, pin_oe, cap_flag;
    logic [15:0] cap_value;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_cap = '0;

    always #5 clk = ~clk;

    tmr_chan_stage i_tmr_chan_stage (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ref_in(ref_in), .pin_in(pin_in), .count_in(count_in),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .pin_out(pin_out), .pin_oe(pin_oe),
        .cap_value(cap_value), .cap_flag(cap_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk);
        flag_we = 1'b1; flag_wdata = v;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    // code = {bit3, bit1}; rising selects the pin transition direction
    task automatic run_cap(input logic md, input logic [1:0] code, input logic en,
                           input logic rising, input logic clr_at_hit, input logic [15:0] cnt);
        logic hit;
        mode_in = 1'b1;
        wr_cfg(16'h0000);
        pin_in = ~rising;
        repeat (4) @(negedge clk);
        wr_flag(1'b0);
        chk(cap_flag == 1'b0, "R12 clear", {15'b0, cap_flag}, 16'h0);
        mode_in = md;
        wr_cfg({12'b0, code[1], 1'b0, code[0], en});
        hit = md && en && ((code == 2'b00 && rising) || (code == 2'b01 && !rising) || code == 2'b11);
        count_in = cnt;
        pin_in = rising;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(cap_value == exp_cap, "R7 latency", cap_value, exp_cap);
        if (clr_at_hit) begin flag_we = 1'b1; flag_wdata = 1'b0; end
        @(posedge clk); @(negedge clk);
        flag_we = 1'b0;
        if (hit) exp_cap = cnt;
        case (code)
            2'b00: chk(cap_value == exp_cap, "R7 rise code", cap_value, exp_cap);
            2'b01: chk(cap_value == exp_cap, "R8 fall code", cap_value, exp_cap);
            2'b11: chk(cap_value == exp_cap, "R9 both code", cap_value, exp_cap);
            default: chk(cap_value == exp_cap, "R10 reserved code", cap_value, exp_cap);
        endcase
        if (!md || !en)
            chk(cap_flag == 1'b0 && cap_value == exp_cap, "R11 blocked", {15'b0, cap_flag}, 16'h0);
        chk(cap_flag == hit, "R12 flag set", {15'b0, cap_flag}, {15'b0, hit});
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cfg_rdata == 16'h0, "R1 cfg", cfg_rdata, 16'h0);
        chk(cap_value == 16'h0, "R1 cap", cap_value, 16'h0);
        chk(cap_flag == 1'b0 && pin_oe == 1'b0, "R1 flag/oe", {14'b0, cap_flag, pin_oe}, 16'h0);

        // Output path sweep: both modes, all 16 low codes, reserved bits set, both ref levels
        for (int md = 0; md < 2; md++) begin
            for (int v = 0; v < 16; v++) begin
                logic [15:0] w;
                w = 16'(v) | (16'(v * 4099 + 17) << 4);
                mode_in = md[0];
                wr_cfg(w);
                chk(cfg_rdata == (w & 16'h000B), "R2 readback", cfg_rdata, w & 16'h000B);
                for (int r = 0; r < 2; r++) begin
                    logic eoe, eout;
                    ref_in = r[0];
                    #1;
                    eoe  = !md[0] && w[0];
                    eout = eoe ? (r[0] ^ w[1]) : 1'b0;
                    if (md[0])
                        chk(pin_oe == 0 && pin_out == 0, "R6 input quiet", {14'b0, pin_oe, pin_out}, 16'h0);
                    else if (!w[0])
                        chk(pin_oe == 0 && pin_out == 0, "R3 off", {14'b0, pin_oe, pin_out}, 16'h0);
                    else if (w[3])
                        chk(pin_oe == eoe && pin_out == eout, "R5 cpol ignored", {14'b0, pin_oe, pin_out}, {14'b0, eoe, eout});
                    else
                        chk(pin_oe == eoe && pin_out == eout, "R4 on", {14'b0, pin_oe, pin_out}, {14'b0, eoe, eout});
                end
            end
        end

        // Capture sweep: every code, enable, direction
        for (int c = 0; c < 4; c++)
            for (int e = 0; e < 2; e++)
                for (int rz = 0; rz < 2; rz++)
                    run_cap(1'b1, c[1:0], e[0], rz[0], 1'b0, 16'(16'h1000 + c * 64 + e * 8 + rz * 3 + 1));

        // Output mode with a capturing code: no capture
        run_cap(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 16'hBEEF);
        chk(cap_value != 16'hBEEF, "R11 output mode", cap_value, exp_cap);

        // Flag write of 1 has no effect; write of 0 clears
        run_cap(1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 16'h4242);
        wr_flag(1'b1);
        chk(cap_flag == 1'b1, "R12 write one", {15'b0, cap_flag}, 16'h1);
        repeat (3) @(negedge clk);
        chk(cap_flag == 1'b1, "R12 sticky", {15'b0, cap_flag}, 16'h1);
        wr_flag(1'b0);
        chk(cap_flag == 1'b0, "R12 write zero", {15'b0, cap_flag}, 16'h0);

        // Clear in the same cycle as a capture: capture wins
        run_cap(1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 16'h7A7A);
        chk(cap_flag == 1'b1, "R12 capture beats clear", {15'b0, cap_flag}, 16'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule